// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block sequences the pad drivers of one 8-bit microcontroller port. Each pin can be driven from a port latch as quasi-bidirectional I/O, from the low byte of an external address bus, or from a per-pin alternate function. For every pin the block produces three enables: a strong pulldown, a strong pullup, and a weak hold. In I/O mode the weak hold acts as a weak pullup. During an address hold it acts as a weak keeper. The analog pad stages consume these enables. Port reads return the pad levels through a two-flop synchroniser.

Every new drive value on a pin begins with a one-cycle break in which both strong drivers are off. The break is followed by a strong phase. A quasi-bidirectional 1 is driven strongly for `RISE_CYCLES` clocks and then falls back to the weak pullup. A 0 keeps the strong pulldown on. An address bit is driven strongly at either level for `ADDR_CYCLES` clocks and then left on the keeper. An alternate function that belongs to the memory interface is driven strongly at both levels for as long as it is selected. Any new value that arrives during a strong phase starts the sequence again.

Top module: `qbPortDrive`

## Requirements
- R1: While reset is asserted and after it is released, every port latch bit is 1. Address mode then has no effect until it is selected. Only the weak hold enables are on (all 1s). Both strong enable vectors are 0, and `readData` is 0xFF.
- R2: When `memMode` is 0 and no alternate function takes a pin, the pin follows its latch bit. A latch write strobed at edge k becomes the pin target at edge k+1. A 0 target gives a one-cycle break and then a continuous strong pulldown.
- R3: When a quasi-bidirectional pin goes to 1, the sequence is one break cycle, then `RISE_CYCLES` cycles of strong pullup, then the weak pullup alone.
- R4: A change of a pin's target or drive kind during its break or strong phase restarts the sequence with a new break cycle. The strong phase then runs its full length.
- R5: A pin never has its strong pullup and strong pulldown on in the same cycle. Neither strong driver turns on in the cycle right after the other one was on.
- R6: When `memMode` is 1, every pin targets `addrLow`, taken at the same edge. After the break cycle, each pin is driven strongly at its level (pullup for 1, pulldown for 0) for `ADDR_CYCLES` cycles. After that only the weak keeper is on.
- R7: An alternate function takes over a pin only when its `altEn` bit is 1 and its latch bit is 1. It then drives `altVal` by the quasi-bidirectional rules. A pin whose latch bit is 0 stays pulled down whatever `altVal` holds.
- R8: A pin taken by an alternate function whose `altMemIf` bit is 1 is driven strongly at the `altVal` level, after one break cycle, for as long as that function is selected.
- R9: `readData` equals `padIn` as sampled two clock edges earlier, independent of the latch contents.
- R10: The weak hold enable of a pin is on exactly when neither of its strong drivers is on.
- R11: Leaving address mode makes each pin target its latch bit or alternate function again. The pin restarts its sequence with a break cycle even if its level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latchWrEn | input | 1 | Port latch write strobe |
| latchWrData | input | 8 | Data written to the port latch |
| memMode | input | 1 | 1 selects the address byte as the pin source |
| addrLow | input | 8 | Low byte of the external address |
| altEn | input | 8 | Per-pin alternate-function enable |
| altVal | input | 8 | Per-pin alternate-function output level |
| altMemIf | input | 8 | Per-pin flag: alternate function belongs to the memory interface |
| padIn | input | 8 | Sampled pad levels |
| pullDnEn | output | 8 | Strong pulldown enables |
| pullUpStrongEn | output | 8 | Strong pullup enables |
| weakHoldEn | output | 8 | Weak pullup / keeper enables |
| readData | output | 8 | Synchronised pad levels returned on port read |

## Verification
A change on `memMode`, `addrLow`, `altEn`, `altVal` or `altMemIf` shows up as a break cycle on the outputs just after the next clock edge. A latch write shows up one edge later, because the latch register lies in the path. The strong phase then occupies the following `RISE_CYCLES` or `ADDR_CYCLES` edges. `readData` trails `padIn` by two edges. The bench's reference model steps on each rising edge using the inputs held since the previous falling edge. It compares every output 1 ns after that edge, so each expected value is checked in exactly the cycle it becomes due.

// File: rtl/qbPortPkg.sv
package qbPortPkg;

  // How a pin's target level is driven once the break cycle is over.
  typedef enum logic [1:0] {
    DRV_QUASI  = 2'd0,  // 0: continuous pulldown, 1: strong window then weak pullup
    DRV_ADDR   = 2'd1,  // strong both levels for a window, then keeper
    DRV_MEMALT = 2'd2   // strong both levels continuously
  } drvKindT;

  typedef enum logic [1:0] {
    PH_GAP    = 2'd0,
    PH_STRONG = 2'd1,
    PH_HOLD   = 2'd2
  } phaseT;

  // Per-pin strobe bundle from control to datapath.
  typedef struct packed {
    logic    restart;
    logic    level;
    drvKindT kind;
  } pinStrobeT;

endpackage

// File: rtl/qbPortCtrl.sv
module qbPortCtrl
  import qbPortPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    latchWrEn,
  input  logic [WIDTH-1:0]        latchWrData,
  input  logic                    memMode,
  input  logic [WIDTH-1:0]        addrLow,
  input  logic [WIDTH-1:0]        altEn,
  input  logic [WIDTH-1:0]        altVal,
  input  logic [WIDTH-1:0]        altMemIf,
  output pinStrobeT [WIDTH-1:0]   strobes
);

  logic [WIDTH-1:0] portLatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      portLatch <= '1;
    end else if (latchWrEn) begin
      portLatch <= latchWrData;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : gPin
    logic    tgtLevel;
    drvKindT tgtKind;
    logic    lastLevel;
    drvKindT lastKind;
    logic    altTakes;

    assign altTakes = altEn[i] & portLatch[i];

    always_comb begin
      if (memMode) begin
        tgtLevel = addrLow[i];
        tgtKind  = DRV_ADDR;
      end else if (altTakes) begin
        tgtLevel = altVal[i];
        tgtKind  = altMemIf[i] ? DRV_MEMALT : DRV_QUASI;
      end else begin
        tgtLevel = portLatch[i];
        tgtKind  = DRV_QUASI;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lastLevel <= 1'b1;
        lastKind  <= DRV_QUASI;
      end else begin
        lastLevel <= tgtLevel;
        lastKind  <= tgtKind;
      end
    end

    assign strobes[i].restart = (tgtLevel != lastLevel) || (tgtKind != lastKind);
    assign strobes[i].level   = tgtLevel;
    assign strobes[i].kind    = tgtKind;
  end

endmodule

// File: rtl/qbPortDatapath.sv
module qbPortDatapath
  import qbPortPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int RISE_CYCLES = 2,
  parameter int ADDR_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pinStrobeT [WIDTH-1:0]   strobes,
  input  logic [WIDTH-1:0]        padIn,
  output logic [WIDTH-1:0]        pullDnEn,
  output logic [WIDTH-1:0]        pullUpStrongEn,
  output logic [WIDTH-1:0]        weakHoldEn,
  output logic [WIDTH-1:0]        readData
);

  localparam int MAX_CYCLES = (RISE_CYCLES > ADDR_CYCLES) ? RISE_CYCLES : ADDR_CYCLES;
  localparam int CW         = $clog2(MAX_CYCLES + 1);
  localparam logic [CW-1:0] RISE_LOAD = CW'(RISE_CYCLES - 1);
  localparam logic [CW-1:0] ADDR_LOAD = CW'(ADDR_CYCLES - 1);

  for (genvar i = 0; i < WIDTH; i++) begin : gPin
    phaseT         phase;
    logic [CW-1:0] cnt;
    logic          lvl;
    drvKindT       kind;
    logic          strongOn;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phase <= PH_HOLD;
        cnt   <= '0;
        lvl   <= 1'b1;
        kind  <= DRV_QUASI;
      end else if (strobes[i].restart) begin
        phase <= PH_GAP;
        lvl   <= strobes[i].level;
        kind  <= strobes[i].kind;
      end else begin
        case (phase)
          PH_GAP: begin
            phase <= PH_STRONG;
            cnt   <= (kind == DRV_ADDR) ? ADDR_LOAD : RISE_LOAD;
          end
          PH_STRONG: begin
            if (cnt == '0) phase <= PH_HOLD;
            else           cnt   <= cnt - 1'b1;
          end
          default: phase <= PH_HOLD;
        endcase
      end
    end

    always_comb begin
      case (phase)
        PH_GAP:    strongOn = 1'b0;
        PH_STRONG: strongOn = 1'b1;
        default: begin
          case (kind)
            DRV_MEMALT: strongOn = 1'b1;
            DRV_ADDR:   strongOn = 1'b0;
            default:    strongOn = ~lvl;   // quasi 0 keeps its pulldown
          endcase
        end
      endcase
    end

    assign pullUpStrongEn[i] = strongOn & lvl;
    assign pullDnEn[i]       = strongOn & ~lvl;
    assign weakHoldEn[i]     = ~strongOn;
  end

  logic [WIDTH-1:0] syncA, syncB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '1;
      syncB <= '1;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign readData = syncB;

endmodule

// File: rtl/qbPortDrive.sv
module qbPortDrive
  import qbPortPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int RISE_CYCLES = 2,
  parameter int ADDR_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latchWrEn,
  input  logic [WIDTH-1:0] latchWrData,
  input  logic             memMode,
  input  logic [WIDTH-1:0] addrLow,
  input  logic [WIDTH-1:0] altEn,
  input  logic [WIDTH-1:0] altVal,
  input  logic [WIDTH-1:0] altMemIf,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] pullDnEn,
  output logic [WIDTH-1:0] pullUpStrongEn,
  output logic [WIDTH-1:0] weakHoldEn,
  output logic [WIDTH-1:0] readData
);

  pinStrobeT [WIDTH-1:0] strobes;

  qbPortCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .latchWrEn   (latchWrEn),
    .latchWrData (latchWrData),
    .memMode     (memMode),
    .addrLow     (addrLow),
    .altEn       (altEn),
    .altVal      (altVal),
    .altMemIf    (altMemIf),
    .strobes     (strobes)
  );

  qbPortDatapath #(
    .WIDTH       (WIDTH),
    .RISE_CYCLES (RISE_CYCLES),
    .ADDR_CYCLES (ADDR_CYCLES)
  ) uData (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .padIn          (padIn),
    .pullDnEn       (pullDnEn),
    .pullUpStrongEn (pullUpStrongEn),
    .weakHoldEn     (weakHoldEn),
    .readData       (readData)
  );

endmodule

// File: rtl/qbPortDrive_chk.sv
module qbPortDrive_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] pullDnEn,
  input logic [WIDTH-1:0] pullUpStrongEn,
  input logic [WIDTH-1:0] weakHoldEn,
  input logic [WIDTH-1:0] readData
);

  logic [1:0] sinceReset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  // R5: never both strong drivers on one pin
  assert_no_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pullDnEn & pullUpStrongEn) == '0);

  // R5: pulldown never follows a pullup cycle directly
  assert_gap_before_pulldown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pullUpStrongEn) & pullDnEn) == '0);

  // R5: pullup never follows a pulldown cycle directly
  assert_gap_before_pullup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pullDnEn) & pullUpStrongEn) == '0);

  // R10: weak hold exactly when no strong driver
  assert_weak_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    weakHoldEn == ~(pullDnEn | pullUpStrongEn));

  // R9: read path trails the pads by two edges
  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceReset >= 2'd2) |-> (readData == $past(padIn, 2)));

endmodule

bind qbPortDrive qbPortDrive_chk #(.WIDTH(WIDTH)) uChk (
  .clk            (clk),
  .rst_n          (rst_n),
  .padIn          (padIn),
  .pullDnEn       (pullDnEn),
  .pullUpStrongEn (pullUpStrongEn),
  .weakHoldEn     (weakHoldEn),
  .readData       (readData)
);

// File: tb/qbPortDrive_test.sv
`timescale 1ns/1ps
module qbPortDrive_test;

  localparam int W    = 8;
  localparam int RISE = 2;
  localparam int ADDR = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         latchWrEn = 1'b0;
  logic [W-1:0] latchWrData = '0;
  logic         memMode = 1'b0;
  logic [W-1:0] addrLow = '0;
  logic [W-1:0] altEn = '0;
  logic [W-1:0] altVal = '0;
  logic [W-1:0] altMemIf = '0;
  logic [W-1:0] padIn = '1;
  logic [W-1:0] pullDnEn, pullUpStrongEn, weakHoldEn, readData;

  always #2 clk = ~clk;   // 250 MHz

  qbPortDrive #(.WIDTH(W), .RISE_CYCLES(RISE), .ADDR_CYCLES(ADDR)) uut (
    .clk(clk), .rst_n(rst_n), .latchWrEn(latchWrEn), .latchWrData(latchWrData),
    .memMode(memMode), .addrLow(addrLow), .altEn(altEn), .altVal(altVal),
    .altMemIf(altMemIf), .padIn(padIn), .pullDnEn(pullDnEn),
    .pullUpStrongEn(pullUpStrongEn), .weakHoldEn(weakHoldEn), .readData(readData)
  );

  int    testsRun = 0;
  int    testsFailed = 0;
  string curTag = "R1";
  bit    done = 0;

  // Reference model: phase 0 break, 1 strong, 2 settled; kind 0 quasi, 1 address, 2 memory alt
  int         mPhase[W];
  int         mLeft[W];
  int         mKind[W];
  bit         mLvl[W];
  bit [W-1:0] mLatch;
  bit [W-1:0] padHist[$];

  task automatic modelReset();
    for (int i = 0; i < W; i++) begin
      mPhase[i] = 2; mLeft[i] = 0; mKind[i] = 0; mLvl[i] = 1'b1;
    end
    mLatch = '1;
    padHist.delete();
  endtask

  task automatic modelStep();
    for (int i = 0; i < W; i++) begin
      bit t; int k;
      if (memMode) begin t = addrLow[i]; k = 1; end
      else if (altEn[i] && mLatch[i]) begin t = altVal[i]; k = altMemIf[i] ? 2 : 0; end
      else begin t = mLatch[i]; k = 0; end
      if (t != mLvl[i] || k != mKind[i]) begin
        mPhase[i] = 0; mLvl[i] = t; mKind[i] = k;
      end else if (mPhase[i] == 0) begin
        mPhase[i] = 1; mLeft[i] = (k == 1) ? ADDR : RISE;
      end else if (mPhase[i] == 1) begin
        mLeft[i]--;
        if (mLeft[i] == 0) mPhase[i] = 2;
      end
    end
    if (latchWrEn) mLatch = latchWrData;
    padHist.push_front(padIn);
    if (padHist.size() > 4) void'(padHist.pop_back());
  endtask

  task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", curTag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [W-1:0] eUp, eDn, eWk, eRd;
    for (int i = 0; i < W; i++) begin
      bit s;
      if (mPhase[i] == 0)      s = 0;
      else if (mPhase[i] == 1) s = 1;
      else if (mKind[i] == 2)  s = 1;
      else if (mKind[i] == 1)  s = 0;
      else                     s = !mLvl[i];
      eUp[i] = s & mLvl[i];
      eDn[i] = s & !mLvl[i];
      eWk[i] = !s;
    end
    eRd = (padHist.size() >= 2) ? padHist[1] : '1;
    check("pullUpStrongEn", pullUpStrongEn, eUp);
    check("pullDnEn", pullDnEn, eDn);
    check("weakHoldEn", weakHoldEn, eWk);
    check("readData", readData, eRd);
  endtask

  always @(posedge clk) begin
    if (!rst_n) modelReset();
    else        modelStep();
    #1;
    if (!done) compareAll();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeLatch(logic [W-1:0] v);
    latchWrEn = 1'b1; latchWrData = v;
    @(negedge clk);
    latchWrEn = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    modelReset();
    curTag = "R1";
    cyc(3);
    check("R1 weak only in reset", weakHoldEn, '1);
    rst_n = 1'b1;
    cyc(4);
    check("R1 weak only after reset", weakHoldEn, '1);
    check("R1 read reset value", readData, 8'hFF);

    curTag = "R2";
    writeLatch(8'h5A); cyc(6);
    writeLatch(8'h00); cyc(5);

    curTag = "R3";
    writeLatch(8'hFF); cyc(6);
    writeLatch(8'h0F); cyc(3);
    writeLatch(8'hFF); cyc(6);

    curTag = "R4";
    writeLatch(8'h00); cyc(5);
    writeLatch(8'hFF);
    writeLatch(8'h00);
    writeLatch(8'hFF); cyc(2);
    writeLatch(8'hC3); cyc(6);

    curTag = "R6";
    memMode = 1'b1; addrLow = 8'h12; cyc(7);
    addrLow = 8'h13; cyc(1);
    addrLow = 8'hEC; cyc(2);
    addrLow = 8'h00; cyc(6);
    addrLow = 8'hFF; cyc(6);

    curTag = "R11";
    addrLow = 8'hC3; cyc(6);
    memMode = 1'b0; cyc(6);

    curTag = "R7";
    writeLatch(8'h0F);
    altEn = 8'hFF; altMemIf = '0; altVal = 8'hAA; cyc(6);
    altVal = 8'h55; cyc(6);
    altEn = 8'h3C; cyc(6);

    curTag = "R8";
    altEn = 8'hFF; altMemIf = 8'h3C; altVal = 8'h0A; cyc(8);
    altVal = 8'h05; cyc(8);
    altMemIf = 8'h00; cyc(6);
    altEn = 8'h00; cyc(4);

    curTag = "R9";
    for (int j = 0; j < 16; j++) begin
      padIn = 8'(j * 37 + 5); cyc(1);
    end

    curTag = "R5";
    for (int j = 0; j < 400; j++) begin
      if (j == 200) curTag = "R10";
      latchWrEn   = ($urandom_range(0, 3) == 0);
      latchWrData = 8'($urandom);
      memMode     = ($urandom_range(0, 7) == 0) ? ~memMode : memMode;
      addrLow     = ($urandom_range(0, 2) == 0) ? 8'($urandom) : addrLow;
      altEn       = ($urandom_range(0, 5) == 0) ? 8'($urandom) : altEn;
      altVal      = ($urandom_range(0, 3) == 0) ? 8'($urandom) : altVal;
      altMemIf    = ($urandom_range(0, 7) == 0) ? 8'($urandom) : altMemIf;
      padIn       = 8'($urandom);
      cyc(1);
    end
    latchWrEn = 1'b0;
    cyc(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule